// File: doc/BRIEF.md
# Power-of-Two Region Memory Protection Checker

This block decides, for every instruction fetch and data access, whether the access is permitted by a small table of protection regions. Each region is a naturally aligned block whose size is a power of two. Both its base and its size are encoded in a single address register, with the size given by the count of trailing ones. A configuration byte next to each address register holds the read, write and execute permissions, a match-mode field and a lock bit. Only the aligned power-of-two mode ever matches.

Software fills the table through a simple register write port. The port selects a region index and chooses between that region's configuration byte and its address register. The same selection drives a combinational read-back port. The core presents each access as a byte address, an access kind and a privilege flag. One cycle later the block returns a result strobe and a fault flag, which the core uses to raise its own trap.

A compile-time granularity value G sets the smallest region the table can express to 2^(G+2) bytes. Address-register bits below that size are held at one.

Top module: `pmp_napot_chk`

## Requirements
- R1: After reset every configuration byte reads 0. Every address register reads 0 except bits [G-2:0], which read as ones. `chk_vld_o` and `fault_o` are 0.
- R2: The configuration byte is laid out as bit 0 read, bit 1 write, bit 2 execute, bits 4:3 mode and bit 7 lock. Bits 6:5 always read 0.
- R3: An address register stores bits [AW-3:0] of the written word, which is the byte address shifted right by two. Bits [G-2:0] are forced to one, so no region is smaller than 2^(G+2) bytes. Writes to a region index at or above NREG have no effect, and such an index reads 0.
- R4: With mode 2'b11, an address register with k trailing ones covers the 2^(k+3)-byte block containing address (value<<2). A register of all ones covers the whole address space.
- R5: A region whose mode is 2'b00, 2'b01 or 2'b10 never matches.
- R6: When several regions match, the region with the lowest index alone supplies the permissions.
- R7: For a user-mode access (`acc_mach_i`=0), the permission bit of the matching region for the access kind decides. If no region matches, the access faults.
- R8: A machine-mode access is allowed when no region matches or when the matching region is unlocked. When the matching region is locked, its permission bits decide.
- R9: While a region's lock bit is set, writes to its configuration byte and its address register are ignored until reset.
- R10: `chk_vld_o` is high exactly in the cycle after `acc_vld_i` was high. `fault_o` carries that access's result and is 0 whenever `chk_vld_o` is 0.
- R11: Access kind encoding is 0 execute, 1 read, 2 write. Kind 3 always faults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| csr_we_i | input | 1 | Register write strobe |
| csr_addr_sel_i | input | 1 | 1 selects the address register, 0 selects the configuration byte |
| csr_idx_i | input | 3 | Region index |
| csr_wdata_i | input | AW-2 | Write data (configuration byte in bits 7:0) |
| csr_rdata_o | output | AW-2 | Read-back of the selected register |
| acc_vld_i | input | 1 | Access present |
| acc_addr_i | input | AW | Access byte address |
| acc_kind_i | input | 2 | Access kind (0 exec, 1 read, 2 write) |
| acc_mach_i | input | 1 | 1 machine mode, 0 user mode |
| chk_vld_o | output | 1 | Result strobe, one cycle after the access |
| fault_o | output | 1 | Access not permitted |

## Verification
The assertions check the following on every cycle:
- a locked region's registers never change;
- the priority selector never picks a region when a lower-numbered region also hits;
- a user access that misses every region, or any access of kind 3, faults one cycle later;
- a machine access that does not hit a locked region never faults;
- a fault only appears with the result strobe.

The bench's address sweeps are the only evidence that region bases and sizes decode correctly, including the forced low bits. They also show that the permission bits are picked per access kind, and that reset clears a lock.

// File: rtl/pmp_napot_pkg.sv
package pmp_napot_pkg;
  typedef enum logic [1:0] {
    ACC_EXEC  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_kind_e;

  typedef logic [7:0] cfg_t;

  localparam int          CFG_R      = 0;
  localparam int          CFG_W      = 1;
  localparam int          CFG_X      = 2;
  localparam int          CFG_L      = 7;
  localparam logic [1:0]  MODE_NAPOT = 2'b11;
  localparam cfg_t        CFG_WMASK  = 8'h9F;
  localparam int          MAX_REGION = 8;
endpackage

// File: rtl/pmp_napot_region.sv
module pmp_napot_region
  import pmp_napot_pkg::*;
#(
  parameter int AW   = 32,
  parameter int GRAN = 14
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic          addr_we_i,
  input  logic [AW-3:0] wdata_i,
  input  logic [AW-1:0] acc_addr_i,
  output cfg_t          cfg_o,
  output logic [AW-3:0] addr_o,
  output logic          hit_o
);
  localparam int PW    = AW - 2;
  localparam int FORCE = (GRAN >= 2) ? GRAN - 1 : 0;
  localparam logic [PW-1:0] FMASK = PW'((64'd1 << FORCE) - 64'd1);

  cfg_t          cfg_q, cfg_d;
  logic [PW-1:0] addr_q, addr_d;
  logic          locked, reg_en;
  logic [PW-1:0] span;
  logic [AW-1:0] mask_full, base_full;

  // next state: a locked region ignores both writes
  always_comb begin
    locked = cfg_q[CFG_L];
    reg_en = (cfg_we_i || addr_we_i) && !locked;
    cfg_d  = cfg_q;
    addr_d = addr_q;
    if (cfg_we_i)  cfg_d  = wdata_i[7:0] & CFG_WMASK;
    if (addr_we_i) addr_d = wdata_i | FMASK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      addr_q <= FMASK;
    end else if (reg_en) begin
      cfg_q  <= cfg_d;
      addr_q <= addr_d;
    end
  end

  // trailing ones plus the first zero mark the bits inside the block
  always_comb begin
    span      = addr_q ^ (addr_q + 1'b1);
    mask_full = {span, 2'b11};
    base_full = {addr_q, 2'b00};
    hit_o     = (cfg_q[4:3] == MODE_NAPOT) &&
                (((acc_addr_i ^ base_full) & ~mask_full) == '0);
  end

  assign cfg_o  = cfg_q;
  assign addr_o = addr_q;

  p_lock_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cfg_q[CFG_L]) |-> ($stable(cfg_q) && $stable(addr_q)));
endmodule

// File: rtl/pmp_napot_prio.sv
module pmp_napot_prio
  import pmp_napot_pkg::*;
#(
  parameter int NREG = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NREG-1:0] hits_i,
  input  cfg_t            cfgs_i [NREG],
  output logic            found_o,
  output cfg_t            sel_cfg_o
);
  localparam int IW = (NREG > 1) ? $clog2(NREG) : 1;

  logic [IW-1:0]   sel_idx;
  logic [NREG-1:0] below_mask;

  // scan from the top so the lowest hit is the last assignment
  always_comb begin
    found_o   = 1'b0;
    sel_cfg_o = '0;
    sel_idx   = '0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (hits_i[i]) begin
        found_o   = 1'b1;
        sel_cfg_o = cfgs_i[i];
        sel_idx   = IW'(i);
      end
    end
  end

  always_comb begin
    for (int j = 0; j < NREG; j++) below_mask[j] = (j < int'(sel_idx));
  end

  p_lowest_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    found_o |-> (hits_i[sel_idx] && ((hits_i & below_mask) == '0)));
endmodule

// File: rtl/pmp_napot_chk.sv
module pmp_napot_chk
  import pmp_napot_pkg::*;
#(
  parameter int NREG = 4,
  parameter int GRAN = 14,
  parameter int AW   = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          csr_we_i,
  input  logic          csr_addr_sel_i,
  input  logic [2:0]    csr_idx_i,
  input  logic [AW-3:0] csr_wdata_i,
  output logic [AW-3:0] csr_rdata_o,
  input  logic          acc_vld_i,
  input  logic [AW-1:0] acc_addr_i,
  input  logic [1:0]    acc_kind_i,
  input  logic          acc_mach_i,
  output logic          chk_vld_o,
  output logic          fault_o
);
  localparam int PW = AW - 2;

  logic [NREG-1:0] hits;
  cfg_t            cfgs  [NREG];
  logic [PW-1:0]   addrs [NREG];
  logic            found, perm_ok, allow;
  cfg_t            sel_cfg;
  acc_kind_e       kind;
  logic            vld_q, vld_d, fault_q, fault_d;

  for (genvar g = 0; g < NREG; g++) begin : g_region
    logic sel_me;
    assign sel_me = csr_we_i && (csr_idx_i == 3'(g));
    pmp_napot_region #(.AW(AW), .GRAN(GRAN)) u_region (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cfg_we_i   (sel_me && !csr_addr_sel_i),
      .addr_we_i  (sel_me && csr_addr_sel_i),
      .wdata_i    (csr_wdata_i),
      .acc_addr_i (acc_addr_i),
      .cfg_o      (cfgs[g]),
      .addr_o     (addrs[g]),
      .hit_o      (hits[g])
    );
  end

  always_comb begin
    csr_rdata_o = '0;
    for (int i = 0; i < NREG; i++) begin
      if (csr_idx_i == 3'(i))
        csr_rdata_o = csr_addr_sel_i ? addrs[i] : PW'(cfgs[i]);
    end
  end

  pmp_napot_prio #(.NREG(NREG)) u_prio (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hits_i    (hits),
    .cfgs_i    (cfgs),
    .found_o   (found),
    .sel_cfg_o (sel_cfg)
  );

  always_comb begin
    kind = acc_kind_e'(acc_kind_i);
    case (kind)
      ACC_EXEC:  perm_ok = sel_cfg[CFG_X];
      ACC_READ:  perm_ok = sel_cfg[CFG_R];
      ACC_WRITE: perm_ok = sel_cfg[CFG_W];
      default:   perm_ok = 1'b0;
    endcase
    if (kind == ACC_RSVD) allow = 1'b0;
    else if (found)       allow = (acc_mach_i && !sel_cfg[CFG_L]) || perm_ok;
    else                  allow = acc_mach_i;
    vld_d   = acc_vld_i;
    fault_d = acc_vld_i && !allow;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q   <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      vld_q   <= vld_d;
      fault_q <= fault_d;
    end
  end

  assign chk_vld_o = vld_q;
  assign fault_o   = fault_q;

  p_fault_qual_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> chk_vld_o);
  p_user_miss_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_vld_i && !acc_mach_i && (hits == '0)) |=> fault_o);
  p_mach_free_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_vld_i && acc_mach_i && (acc_kind_i != 2'd3) && !(found && sel_cfg[CFG_L]))
      |=> !fault_o);
  p_rsvd_kind_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_vld_i && (acc_kind_i == 2'd3)) |=> fault_o);
endmodule

// File: tb/pmp_napot_chk_tb.sv
module pmp_napot_chk_tb;
  localparam int NREG = 4;
  localparam int GRAN = 3;
  localparam int AW   = 32;
  localparam int PW   = AW - 2;
  localparam logic [PW-1:0] LOWONES = 30'h3;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n;
  logic          csr_we, csr_sel;
  logic [2:0]    csr_idx;
  logic [PW-1:0] csr_wdata, csr_rdata;
  logic          acc_vld, acc_mach, chk_vld, fault;
  logic [AW-1:0] acc_addr;
  logic [1:0]    acc_kind;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [7:0]    mcfg  [NREG];
  logic [PW-1:0] maddr [NREG];

  pmp_napot_chk #(.NREG(NREG), .GRAN(GRAN), .AW(AW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .csr_we_i(csr_we), .csr_addr_sel_i(csr_sel), .csr_idx_i(csr_idx),
    .csr_wdata_i(csr_wdata), .csr_rdata_o(csr_rdata),
    .acc_vld_i(acc_vld), .acc_addr_i(acc_addr), .acc_kind_i(acc_kind),
    .acc_mach_i(acc_mach), .chk_vld_o(chk_vld), .fault_o(fault)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NREG; i++) begin
      mcfg[i]  = 8'h00;
      maddr[i] = LOWONES;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    model_reset();
    rst_n = 1'b1;
  endtask

  task automatic wr(bit is_addr, int idx, logic [PW-1:0] d);
    @(negedge clk);
    csr_we = 1'b1; csr_sel = is_addr; csr_idx = 3'(idx); csr_wdata = d;
    if (idx < NREG && !mcfg[idx][7]) begin
      if (is_addr) maddr[idx] = d | LOWONES;
      else         mcfg[idx]  = d[7:0] & 8'h9F;
    end
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic rd(string req, bit is_addr, int idx);
    logic [PW-1:0] e;
    @(negedge clk);
    csr_sel = is_addr; csr_idx = 3'(idx);
    #1;
    if (idx >= NREG) e = '0;
    else             e = is_addr ? maddr[idx] : PW'(mcfg[idx]);
    chk(req, 64'(csr_rdata), 64'(e));
  endtask

  function automatic bit exp_fault(longint addr, int kind, bit mach);
    if (kind == 3) return 1'b1;
    for (int i = 0; i < NREG; i++) begin
      if (mcfg[i][4:3] == 2'b11) begin
        int k = 0;
        bit hit;
        while (k < PW && maddr[i][k]) k++;
        if (k == PW) hit = 1'b1;
        else begin
          longint size = longint'(1) << (k + 3);
          longint base = ((longint'(maddr[i]) * 4) / size) * size;
          hit = (addr >= base) && (addr < base + size);
        end
        if (hit) begin
          bit perm;
          if (mach && !mcfg[i][7]) return 1'b0;
          perm = (kind == 0) ? mcfg[i][2] : (kind == 1) ? mcfg[i][0] : mcfg[i][1];
          return !perm;
        end
      end
    end
    return !mach;
  endfunction

  task automatic acc(string req, longint addr, int kind, bit mach);
    @(negedge clk);
    acc_vld = 1'b1; acc_addr = AW'(addr); acc_kind = 2'(kind); acc_mach = mach;
    @(posedge clk);
    #1;
    total++;
    if (chk_vld !== 1'b1 || fault !== exp_fault(addr, kind, mach)) begin
      bad++;
      $display("FAIL %s addr=%0h kind=%0d mach=%0d actual vld=%0b fault=%0b expected vld=1 fault=%0b",
               req, addr, kind, mach, chk_vld, fault, exp_fault(addr, kind, mach));
    end
    @(negedge clk);
    acc_vld = 1'b0;
  endtask

  task automatic sweep(string req);
    for (int a = 0; a < 512; a += 4)
      for (int k = 0; k < 4; k++)
        for (int m = 0; m < 2; m++)
          acc(req, longint'(a), k, m[0]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; csr_we = 1'b0; csr_sel = 1'b0; csr_idx = '0; csr_wdata = '0;
    acc_vld = 1'b0; acc_addr = '0; acc_kind = '0; acc_mach = 1'b0;
    model_reset();
    do_reset();

    // R1 reset state
    chk("R1 chk_vld", 64'(chk_vld), 64'd0);
    chk("R1 fault", 64'(fault), 64'd0);
    for (int i = 0; i < NREG; i++) begin
      rd("R1 cfg", 1'b0, i);
      rd("R1 addr", 1'b1, i);
    end

    // R2 reserved bits, R3 forced low bits and out-of-range index
    wr(1'b0, 3, 30'h79);
    rd("R2 cfg layout", 1'b0, 3);
    chk("R2 bits65", 64'(csr_rdata), 64'h19);
    wr(1'b0, 3, 30'h0);
    wr(1'b1, 1, 30'h20);
    rd("R3 forced ones", 1'b1, 1);
    chk("R3 value", 64'(csr_rdata), 64'h23);
    wr(1'b1, 5, 30'h1234);
    rd("R3 idx range", 1'b1, 5);

    // R4 R5 R7 R8 R11: separate regions, one mode off
    wr(1'b1, 0, 30'h3);   wr(1'b0, 0, 30'h19);  // 0x00-0x1F read only
    wr(1'b1, 1, 30'h17);  wr(1'b0, 1, 30'h1F);  // 0x40-0x7F rwx
    wr(1'b1, 2, 30'h2F);  wr(1'b0, 2, 30'h0F);  // mode 01: off
    wr(1'b1, 3, 30'h41);  wr(1'b0, 3, 30'h1A);  // forced to 0x43: 0x100-0x11F write only
    sweep("R4 R5 R7 R8 R11");

    // R6 overlap: lowest index wins
    wr(1'b1, 0, 30'h7);   wr(1'b0, 0, 30'h1C);  // 0x00-0x3F exec only
    wr(1'b1, 1, 30'h1F);  wr(1'b0, 1, 30'h1B);  // 0x00-0xFF read/write
    wr(1'b0, 2, 30'h0);   wr(1'b0, 3, 30'h0);
    sweep("R6 R7");

    // R8 R9 locked region plus catch-all
    wr(1'b0, 0, 30'h0);   wr(1'b0, 1, 30'h0);
    wr(1'b1, 2, 30'h27);  wr(1'b0, 2, 30'h99);  // 0x80-0xBF read only, locked
    wr(1'b1, 3, 30'h3FFF_FFFF); wr(1'b0, 3, 30'h19);
    sweep("R8 R9");
    wr(1'b0, 2, 30'h1F);
    wr(1'b1, 2, 30'h0);
    rd("R9 cfg kept", 1'b0, 2);
    chk("R9 cfg value", 64'(csr_rdata), 64'h99);
    rd("R9 addr kept", 1'b1, 2);
    chk("R9 addr value", 64'(csr_rdata), 64'h27);
    sweep("R9 after write");

    // R10 strobe drops with no access
    @(negedge clk);
    @(posedge clk); #1;
    chk("R10 idle vld", 64'(chk_vld), 64'd0);
    chk("R10 idle fault", 64'(fault), 64'd0);

    // R9 R1 reset clears the lock
    do_reset();
    rd("R9 reset unlock", 1'b0, 2);
    wr(1'b0, 2, 30'h1B);
    rd("R9 writable again", 1'b0, 2);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule